// File: doc/BRIEF.md
# Eight-Function ALU with Zero Flag

This block is a purely combinational arithmetic and logic unit of parameterised width (32 bits by default). It takes two operands and a 3-bit function code. It returns a result word and a flag that is high whenever that result is zero. A processor datapath uses the unit for register arithmetic, for address generation and, through the zero flag, for equality compares on conditional branches.

A single adder performs both addition and subtraction. The top bit of the function code does two jobs. It replaces the second operand with its bitwise complement, and it feeds the adder's carry-in. The two low bits of the code pick one of four candidate results: the bitwise AND, the bitwise OR, the sum, or a one-bit less-than flag widened with zeros. This sharing gives AND-with-complement, OR-with-complement, subtraction and set-less-than with no extra arithmetic. The one code that has no defined operation returns zero.

The less-than flag is taken straight from the sign bit of the difference. It is therefore wrong whenever the subtraction overflows. For example, the most negative value compared against one reports "not less". Callers that need an exact signed compare must avoid that operand range.

Top module: `eight_fn_alu`

## Requirements
- R1: With function code 3'b000 the result is the bitwise AND of the two operands.
- R2: With function code 3'b001 the result is the bitwise OR of the two operands.
- R3: With function code 3'b010 the result is the operand sum, wrapped modulo 2^WIDTH; no carry is reported.
- R4: With function code 3'b100 the result is A AND (NOT B), and with 3'b101 it is A OR (NOT B).
- R5: With function code 3'b110 the result is A minus B, wrapped modulo 2^WIDTH.
- R6: With function code 3'b111 the result bit 0 equals bit WIDTH-1 of (A - B) wrapped, and all higher bits are zero; when the subtraction overflows the bit is therefore the opposite of the true signed comparison.
- R7: With function code 3'b011 the result is all zeros for any operands.
- R8: The zero flag is high exactly when every bit of the result is zero, for every function code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| fn_i | input | 3 | Function code; bit 2 complements the second operand and sets the carry-in, bits 1:0 select the result |
| res_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when res_o is all zeros |

## Verification
The bound checker watches every input change. It confirms that the zero flag tracks the result and that the undefined code yields zero. It also confirms that the less-than code never sets any bit above bit 0, and that the AND, sum and difference codes match their arithmetic meaning. The bench must cover the rest. That means exact values for the complemented-operand logic codes and the wrap-around of the sum. It also means the overflow case in which the less-than bit disagrees with the true signed order, and a sweep of all codes over the extreme operands and random operands against a reference model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Result selector carried by the two low bits of the function code.
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } res_sel_e;

  // Function code with no defined operation.
  localparam logic [2:0] FN_UNUSED = 3'b011;

  // Position of the complement / carry-in control bit in the function code.
  localparam int unsigned FN_INV_BIT = 2;

endpackage : alu_pkg

// File: rtl/alu_operand_cond.sv
// Conditions the second operand: passes it through or complements it.
module alu_operand_cond #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opb_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] opb_eff_o
);

  // One XOR per bit; the control bit fans out across the word.
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_inv
    assign opb_eff_o[gi] = opb_i[gi] ^ inv_i;
  end

endmodule : alu_operand_cond

// File: rtl/alu_adder.sv
// Shared adder with an explicit carry-in; carry-out is not kept.
module alu_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);

  logic [WIDTH:0] carry;

  assign carry[0] = cin_i;

  // Bit-level ripple description; synthesis is free to restructure it.
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    assign sum_o[gi]    = opa_i[gi] ^ opb_i[gi] ^ carry[gi];
    assign carry[gi+1]  = (opa_i[gi] & opb_i[gi]) |
                          (carry[gi] & (opa_i[gi] ^ opb_i[gi]));
  end

  logic unused_cout;
  assign unused_cout = carry[WIDTH];

endmodule : alu_adder

// File: rtl/alu_result_sel.sv
// Four-way result selection plus forcing of the undefined code to zero.
module alu_result_sel
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] or_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic [2:0]       fn_i,
  output logic [WIDTH-1:0] res_o
);

  localparam int unsigned MSB = WIDTH - 1;

  res_sel_e                sel;
  logic     [WIDTH-1:0]    less_word;
  logic     [WIDTH-1:0]    picked;

  assign sel       = res_sel_e'(fn_i[1:0]);
  // Sign of the difference, widened with zeros.
  assign less_word = {{(WIDTH-1){1'b0}}, sum_i[MSB]};

  always_comb begin
    unique case (sel)
      SEL_AND:  picked = and_i;
      SEL_OR:   picked = or_i;
      SEL_SUM:  picked = sum_i;
      SEL_LESS: picked = less_word;
      default:  picked = '0;
    endcase
  end

  // The code without a defined operation returns zero.
  assign res_o = (fn_i == FN_UNUSED) ? '0 : picked;

endmodule : alu_result_sel

// File: rtl/eight_fn_alu.sv
// Top level: operand conditioning, logic terms, shared adder, selection, zero detect.
module eight_fn_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [2:0]       fn_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o
);

  logic             inv;
  logic [WIDTH-1:0] opb_eff;
  logic [WIDTH-1:0] and_w;
  logic [WIDTH-1:0] or_w;
  logic [WIDTH-1:0] sum_w;

  assign inv = fn_i[FN_INV_BIT];

  alu_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .opb_i     (opb_i),
    .inv_i     (inv),
    .opb_eff_o (opb_eff)
  );

  assign and_w = opa_i & opb_eff;
  assign or_w  = opa_i | opb_eff;

  // Same control bit is the carry-in, so inv=1 yields A + ~B + 1 = A - B.
  alu_adder #(.WIDTH(WIDTH)) u_add (
    .opa_i (opa_i),
    .opb_i (opb_eff),
    .cin_i (inv),
    .sum_o (sum_w)
  );

  alu_result_sel #(.WIDTH(WIDTH)) u_sel (
    .and_i (and_w),
    .or_i  (or_w),
    .sum_i (sum_w),
    .fn_i  (fn_i),
    .res_o (res_o)
  );

  assign zero_o = ~|res_o;

endmodule : eight_fn_alu

// File: rtl/eight_fn_alu_chk.sv
// Property checker attached to every eight_fn_alu instance.
module eight_fn_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [2:0]       fn_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o
);

  always_comb begin
    if (!$isunknown({opa_i, opb_i, fn_i})) begin
      // R8
      zero_flag_chk: assert (zero_o == (res_o == '0));
      // R7
      unused_code_chk: assert (fn_i != 3'b011 || res_o == '0);
      // R6
      less_upper_chk: assert (fn_i != 3'b111 || res_o[WIDTH-1:1] == '0);
      // R1
      and_code_chk: assert (fn_i != 3'b000 || res_o == (opa_i & opb_i));
      // R3
      sum_code_chk: assert (fn_i != 3'b010 || res_o == opa_i + opb_i);
      // R5
      diff_code_chk: assert (fn_i != 3'b110 || res_o == opa_i - opb_i);
    end
  end

endmodule : eight_fn_alu_chk

bind eight_fn_alu eight_fn_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .fn_i   (fn_i),
  .res_o  (res_o),
  .zero_o (zero_o)
);

// File: tb/test_eight_fn_alu.sv
module test_eight_fn_alu;

  localparam int unsigned W    = 32;
  localparam int unsigned NVEC = 14;
  localparam int unsigned VW   = 3 + 3*W + 1;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [2:0]   fn;
  logic [W-1:0] res;
  logic         zero;

  int checks = 0;
  int errors = 0;

  eight_fn_alu #(.WIDTH(W)) i_eight_fn_alu (
    .opa_i  (opa),
    .opb_i  (opb),
    .fn_i   (fn),
    .res_o  (res),
    .zero_o (zero)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {fn, A, B, expected result, expected zero}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {3'b000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0}, // R1
    {3'b001, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 1'b0}, // R2
    {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0}, // R3
    {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1}, // R3 wrap
    {3'b100, 32'hF0F0F0F0, 32'hFF00FF00, 32'h00F000F0, 1'b0}, // R4
    {3'b101, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF0FFF0FF, 1'b0}, // R4
    {3'b110, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0}, // R5
    {3'b110, 32'h12345678, 32'h12345678, 32'h00000000, 1'b1}, // R5 equal
    {3'b111, 32'h00000003, 32'h00000005, 32'h00000001, 1'b0}, // R6
    {3'b111, 32'h00000005, 32'h00000003, 32'h00000000, 1'b1}, // R6
    {3'b111, 32'h80000000, 32'h00000001, 32'h00000000, 1'b1}, // R6 overflow
    {3'b111, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 1'b0}, // R6 negative
    {3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1}, // R7
    {3'b000, 32'hAAAAAAAA, 32'h55555555, 32'h00000000, 1'b1}  // R8
  };

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'b000:         return "R1";
      3'b001:         return "R2";
      3'b010:         return "R3";
      3'b100, 3'b101: return "R4";
      3'b110:         return "R5";
      3'b111:         return "R6";
      default:        return "R7";
    endcase
  endfunction

  // Behavioural model written from the requirements.
  function automatic logic [W-1:0] model(input logic [2:0] f,
                                         input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    logic [W-1:0] d;
    d = a - b;
    case (f)
      3'b000:  return a & b;
      3'b001:  return a | b;
      3'b010:  return a + b;
      3'b100:  return a & ~b;
      3'b101:  return a | ~b;
      3'b110:  return d;
      3'b111:  return {{(W-1){1'b0}}, d[W-1]};
      default: return '0;
    endcase
  endfunction

  task automatic apply_and_check(input logic [2:0] f, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input logic [W-1:0] ey,
                                 input logic ez);
    @(negedge clk);
    fn  = f;
    opa = a;
    opb = b;
    #1;
    checks++;
    if (res !== ey) begin
      errors++;
      $display("FAIL %s fn=%b a=%h b=%h result actual=%h expected=%h",
               req_of(f), f, a, b, res, ey);
    end
    checks++;
    if (zero !== ez) begin
      errors++;
      $display("FAIL R8 fn=%b a=%h b=%h zero actual=%b expected=%b",
               f, a, b, zero, ez);
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] corner [4];
    corner[0] = '0;
    corner[1] = '1;
    corner[2] = {1'b1, {(W-1){1'b0}}};
    corner[3] = {1'b0, {(W-1){1'b1}}};

    rst_n = 1'b0;
    fn    = 3'b000;
    opa   = '0;
    opb   = '0;
    repeat (3) @(posedge clk);
    // Reset-time state: all-zero inputs give a zero result and a set flag (R1, R8).
    apply_and_check(3'b000, '0, '0, '0, 1'b1);
    rst_n = 1'b1;

    // Vector table.
    for (int i = 0; i < NVEC; i++) begin
      apply_and_check(VEC[i][VW-1 -: 3], VEC[i][VW-4 -: W], VEC[i][VW-4-W -: W],
                      VEC[i][W:1], VEC[i][0]);
    end

    // Extreme operands against every code (R1..R7, R8 via zero).
    for (int f = 0; f < 8; f++) begin
      for (int x = 0; x < 4; x++) begin
        for (int y = 0; y < 4; y++) begin
          logic [W-1:0] e;
          e = model(3'(f), corner[x], corner[y]);
          apply_and_check(3'(f), corner[x], corner[y], e, (e == '0));
        end
      end
    end

    // Overflow case of R6: most positive minus most negative reports 1, true order says 0.
    apply_and_check(3'b111, corner[3], corner[2], 32'h00000001, 1'b0);

    // Undefined code (R7) with random operands.
    for (int i = 0; i < 50; i++) begin
      apply_and_check(3'b011, $urandom, $urandom, '0, 1'b1);
    end

    // Random operands across all codes.
    for (int i = 0; i < 2000; i++) begin
      logic [2:0]   f;
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [W-1:0] e;
      f = 3'($urandom);
      a = $urandom;
      b = (i % 7 == 0) ? a : W'($urandom);
      e = model(f, a, b);
      apply_and_check(f, a, b, e, (e == '0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule : test_eight_fn_alu